// File: doc/BRIEF.md
# PWM Generator with Half-Step Duty

This block produces a single pulse-width-modulated output from an 8-bit period and an 8-bit duty value. A programmable divider turns the oscillator clock into the PWM clock. A free-running counter steps once per PWM clock, from 1 up to the period value, and then wraps back to 1. The output is at its active level while the counter is at or below the duty value. A fine-tune bit lengthens the active time by half a PWM clock. A polarity bit selects whether the active level is high or low.

Software programs the block through a narrow write port with a 3-bit address and 4-bit data. Period and duty values are assembled nibble by nibble in staging registers. Writing the last nibble of either value arms it. An armed value moves into the running registers only at the next counter wrap, so a period never mixes old and new settings. An enable bit decides whether the pad carries the PWM signal or is left to general-purpose I/O. The enable is signalled on `pwm_oe_o`.

Top module: `pwm_halfstep`

## Requirements
- R1: After reset, `pwm_oe_o` and `pwm_o` are both 0, the running period is 0 and the control register is 0.
- R2: The control register is at address 0. Bit 0 is the enable, bits 2:1 are the divide code `d`, and bit 3 is the polarity. One PWM clock lasts 2^d oscillator cycles.
- R3: With a nonzero running period P, the output repeats every P PWM clocks.
- R4: With 1 <= duty < P and the fine bit at 0, the output is active for duty PWM clocks in each period.
- R5: With 1 <= duty < P and the fine bit at 1, the active time is duty plus one half PWM clock. The fine bit has no effect when duty is 0 or when duty >= P.
- R6: With polarity 0 the active level is high. With polarity 1 the active level is low.
- R7: With a running period of 0, the enabled output stays constantly at its inactive level: low for polarity 0, high for polarity 1.
- R8: With duty >= P (P nonzero), the enabled output stays at its active level throughout.
- R9: The register addresses are: 1 for period bits 3:0, 2 for period bits 7:4, 3 for the fine bit (data bit 0), 4 for duty bits 3:0 and 5 for duty bits 7:4. Writing address 2 arms the staged period. Writing address 5 arms the staged duty and the staged fine bit. Armed values take effect only at the next counter wrap. Low-nibble or fine writes alone leave the output unchanged.
- R10: With the enable at 0, `pwm_oe_o` is 0 and `pwm_o` is held at 0.
- R11: The PWM output level changes only on PWM clock ticks, apart from the half-clock fine extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 4 | Write data nibble |
| pwm_o | output | 1 | PWM pin value |
| pwm_oe_o | output | 1 | Selects the PWM signal onto the shared pin |

## Verification
Results appear with different latencies. A control write changes the enable and polarity on `pwm_o` one oscillator cycle after the write edge. A change to the divide code is seen at the next tick. A committed period or duty becomes visible only after the running period ends, which can take up to 255 x 8 oscillator cycles. The bench therefore waits a fixed 4200 cycles after each reconfiguration before it measures. Outputs are sampled twice per oscillator cycle, 2 ns after each clock edge, so that a half-cycle extension can be counted. Periods are measured between two successive active-going transitions, and active time is counted inside that span. Because of this, no check depends on the phase of the counter.

// File: rtl/pwm_halfstep_pkg.sv
package pwm_halfstep_pkg;
  localparam int DIV_W = 2;

  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_PER_LO  = 3'd1,
    A_PER_HI  = 3'd2,
    A_FINE    = 3'd3,
    A_DUTY_LO = 3'd4,
    A_DUTY_HI = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic             pol;
    logic [DIV_W-1:0] div;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_halfstep_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [3:0]       wr_data_i,
  input  logic             bnd_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] per_q_o,
  output logic [CNT_W-1:0] per_n_o,
  output logic [CNT_W-1:0] duty_n_o,
  output logic             fine_q_o,
  output logic             fine_n_o
);
  localparam int HI_W = CNT_W - 4;

  logic [CNT_W-1:0] per_stg, duty_stg, per_q, duty_q;
  logic             fine_stg, fine_q, per_pend, duty_pend;
  logic             per_ld, duty_ld;

  assign per_ld   = bnd_i && per_pend;
  assign duty_ld  = bnd_i && duty_pend;
  assign per_n_o  = per_ld ? per_stg : per_q;
  assign duty_n_o = duty_ld ? duty_stg : duty_q;
  assign fine_n_o = duty_ld ? fine_stg : fine_q;
  assign per_q_o  = per_q;
  assign fine_q_o = fine_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      per_stg   <= '0;
      duty_stg  <= '0;
      fine_stg  <= 1'b0;
      per_pend  <= 1'b0;
      duty_pend <= 1'b0;
      per_q     <= '0;
      duty_q    <= '0;
      fine_q    <= 1'b0;
    end else begin
      per_q  <= per_n_o;
      duty_q <= duty_n_o;
      fine_q <= fine_n_o;
      if (per_ld)  per_pend  <= 1'b0;
      if (duty_ld) duty_pend <= 1'b0;
      if (wr_en_i) begin
        case (reg_addr_e'(wr_addr_i))
          A_CTRL:    ctrl_o <= ctrl_t'(wr_data_i);
          A_PER_LO:  per_stg[3:0] <= wr_data_i;
          A_PER_HI: begin
            per_stg[CNT_W-1:4] <= wr_data_i[HI_W-1:0];
            per_pend           <= 1'b1;
          end
          A_FINE:    fine_stg <= wr_data_i[0];
          A_DUTY_LO: duty_stg[3:0] <= wr_data_i;
          A_DUTY_HI: begin
            duty_stg[CNT_W-1:4] <= wr_data_i[HI_W-1:0];
            duty_pend           <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_halfstep_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DCNT_W = (1 << DIV_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  per_q_i,
  input  logic [CNT_W-1:0]  per_n_i,
  input  logic [CNT_W-1:0]  duty_n_i,
  output logic              tick_o,
  output logic              bnd_o,
  output logic [DCNT_W-1:0] dcnt_o,
  output logic [DCNT_W-1:0] lim_o,
  output logic              act_o
);
  logic [DCNT_W-1:0] dcnt_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  assign lim_o  = DCNT_W'((1 << div_i) - 1);
  assign tick_o = (dcnt_q >= lim_o);
  assign dcnt_o = dcnt_q;
  assign bnd_o  = tick_o && ((per_q_i == '0) || (cnt_q >= per_q_i));
  assign cnt_n  = bnd_o ? CNT_W'(1) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      cnt_q  <= '0;
      act_o  <= 1'b0;
    end else begin
      dcnt_q <= tick_o ? '0 : dcnt_q + DCNT_W'(1);
      if (tick_o) begin
        cnt_q <= cnt_n;
        act_o <= (per_n_i != '0) && (cnt_n <= duty_n_i);
      end
    end
  end
endmodule

// File: rtl/pwm_shape.sv
module pwm_shape
  import pwm_halfstep_pkg::*;
#(
  parameter int DCNT_W = (1 << DIV_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DCNT_W-1:0] dcnt_i,
  input  logic [DCNT_W-1:0] lim_i,
  input  logic              act_i,
  input  logic              fine_i,
  input  ctrl_t             ctrl_i,
  output logic              pwm_o,
  output logic              pwm_oe_o
);
  logic ext_q, neg_q, ext, lvl;
  logic [DCNT_W-1:0] half_m1;

  assign half_m1 = lim_i >> 1;

  // divided clock: hold for half a PWM clock after the active phase ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ext_q <= 1'b0;
    else if (tick_i)            ext_q <= act_i && fine_i;
    else if (dcnt_i == half_m1) ext_q <= 1'b0;
  end

  // undivided clock: half a PWM clock is the low phase of clk_i
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= act_i;
  end

  assign ext      = (ctrl_i.div == '0) ? (neg_q && fine_i) : ext_q;
  assign lvl      = act_i || ext;
  assign pwm_o    = ctrl_i.en && (lvl ^ ctrl_i.pol);
  assign pwm_oe_o = ctrl_i.en;
endmodule

// File: rtl/pwm_halfstep.sv
module pwm_halfstep
  import pwm_halfstep_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [3:0] wr_data_i,
  output logic       pwm_o,
  output logic       pwm_oe_o
);
  localparam int DCNT_W = (1 << DIV_W) - 1;

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  per_q, per_n, duty_n;
  logic              fine_q, fine_n, tick, bnd, act_q;
  logic [DCNT_W-1:0] dcnt, lim;

  pwm_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .bnd_i(bnd), .ctrl_o(ctrl), .per_q_o(per_q), .per_n_o(per_n),
    .duty_n_o(duty_n), .fine_q_o(fine_q), .fine_n_o(fine_n)
  );

  pwm_counter #(.CNT_W(CNT_W), .DCNT_W(DCNT_W)) i_cnt (
    .clk_i, .rst_ni, .div_i(ctrl.div), .per_q_i(per_q), .per_n_i(per_n),
    .duty_n_i(duty_n), .tick_o(tick), .bnd_o(bnd), .dcnt_o(dcnt),
    .lim_o(lim), .act_o(act_q)
  );

  pwm_shape #(.DCNT_W(DCNT_W)) i_shape (
    .clk_i, .rst_ni, .tick_i(tick), .dcnt_i(dcnt), .lim_i(lim),
    .act_i(act_q), .fine_i(fine_q), .ctrl_i(ctrl),
    .pwm_o, .pwm_oe_o
  );

  logic unused_fine_n;
  assign unused_fine_n = fine_n;
endmodule

// File: rtl/pwm_halfstep_chk.sv
module pwm_halfstep_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] per_q,
  input logic             bnd,
  input logic             tick,
  input logic             act_q,
  input logic             en,
  input logic             pwm_o,
  input logic             pwm_oe_o
);
  p_commit_at_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_q) |-> $past(bnd))
    else $error("running period changed away from a wrap");

  p_act_on_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(act_q))
    else $error("active phase moved between PWM ticks");

  p_zero_period_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == '0) |-> !act_q)
    else $error("active phase with zero period");

  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (!pwm_o && !pwm_oe_o))
    else $error("pin driven while disabled");
endmodule

bind pwm_halfstep pwm_halfstep_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .per_q(per_q), .bnd(bnd), .tick(tick),
  .act_q(act_q), .en(ctrl.en), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
);

// File: tb/test_pwm_halfstep.sv
module test_pwm_halfstep;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       pwm, pwm_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_halfstep i_pwm_halfstep (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .pwm_oe_o(pwm_oe)
  );

  // {pol, div, period, duty, fine}
  localparam logic [31:0] VEC [12] = '{
    32'h0_0_0A_04_00, 32'h0_0_0A_04_01, 32'h0_1_0C_05_01, 32'h1_2_06_02_00,
    32'h0_3_05_03_01, 32'h0_0_08_08_00, 32'h0_0_08_14_01, 32'h0_1_00_05_00,
    32'h1_0_00_03_00, 32'h0_0_FF_80_00, 32'h0_0_0A_00_01, 32'h0_2_03_01_01
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // samples are taken 2 ns after every clock edge
  task automatic smp(input bit pol, output bit a);
    #5;
    a = pwm ^ pol;
  endtask

  task automatic meas_edges(input bit pol, output int per_s, output int act_s);
    bit prev, a;
    int guard;
    per_s = 0; act_s = 0;
    @(posedge clk); #2;
    prev = pwm ^ pol;
    guard = 0;
    do begin smp(pol, a); guard++; if (a && !prev) break; prev = a; end
    while (guard < 6000);
    if (guard >= 6000) return;
    per_s = 1; act_s = 1; prev = 1'b1;
    guard = 0;
    do begin
      smp(pol, a); guard++;
      if (a && !prev) break;
      per_s++; if (a) act_s++;
      prev = a;
    end while (guard < 6000);
  endtask

  task automatic meas_win(input bit pol, input int win, output int act_s);
    bit a;
    act_s = 0;
    @(posedge clk); #2;
    for (int i = 0; i < win; i++) begin smp(pol, a); if (a) act_s++; end
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ps, as;
    repeat (3) @(negedge clk);
    #1;
    chk(pwm == 1'b0 && pwm_oe == 1'b0, "R1 reset outputs", {pwm, pwm_oe}, 0);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #2;
    chk(pwm == 1'b0 && pwm_oe == 1'b0, "R1 idle after reset", {pwm, pwm_oe}, 0);

    for (int v = 0; v < 12; v++) begin
      logic [31:0] e;
      bit pol, fine;
      int dv, per, duty, d, exp_p, exp_a, win;
      string tag;
      e = VEC[v];
      pol = e[28]; dv = int'(e[25:24]); per = int'(e[23:16]);
      duty = int'(e[15:8]); fine = e[0]; d = 1 << dv;
      wr(3'd0, {pol, dv[1:0], 1'b1});
      wr(3'd1, per[3:0]); wr(3'd2, per[7:4]);
      wr(3'd3, {3'b0, fine});
      wr(3'd4, duty[3:0]); wr(3'd5, duty[7:4]);
      repeat (4200) @(posedge clk);
      if (per != 0 && duty != 0 && duty < per) begin
        exp_p = per * 2 * d;
        exp_a = duty * 2 * d + (fine ? d : 0);
        tag = fine ? "R5 fine extension" : (pol ? "R6 polarity" : "R4 duty");
        meas_edges(pol, ps, as);
        chk(ps == exp_p, $sformatf("R3 R2 period vec%0d", v), ps, exp_p);
        chk(as == exp_a, $sformatf("%s vec%0d", tag, v), as, exp_a);
      end else begin
        win = (per == 0) ? 64 : per * 4 * d;
        exp_a = (per == 0 || duty == 0) ? 0 : win;
        tag = (per == 0) ? "R7 zero period" : (duty == 0 ? "R5 zero duty" : "R8 full duty");
        meas_win(pol, win, as);
        chk(as == exp_a, $sformatf("%s vec%0d", tag, v), as, exp_a);
        if (per == 0) chk(pwm == pol, "R7 level", pwm, pol);
      end
    end

    // R9: staging without the high-nibble write stays invisible
    wr(3'd0, 4'b0001);
    wr(3'd1, 4'hA); wr(3'd2, 4'h0); wr(3'd3, 4'h0);
    wr(3'd4, 4'h4); wr(3'd5, 4'h0);
    repeat (100) @(posedge clk);
    wr(3'd1, 4'h6); wr(3'd4, 4'h2); wr(3'd3, 4'h1);
    repeat (100) @(posedge clk);
    meas_edges(1'b0, ps, as);
    chk(ps == 20, "R9 period unarmed", ps, 20);
    chk(as == 8, "R9 duty unarmed", as, 8);
    wr(3'd2, 4'h0);
    repeat (100) @(posedge clk);
    meas_edges(1'b0, ps, as);
    chk(ps == 12, "R9 period armed", ps, 12);
    chk(as == 8, "R9 duty still unarmed", as, 8);
    wr(3'd5, 4'h0);
    repeat (100) @(posedge clk);
    meas_edges(1'b0, ps, as);
    chk(as == 5, "R9 duty and fine armed", as, 5);

    // R10: disable with inverted polarity keeps the pin released and low
    wr(3'd0, 4'b1000);
    @(posedge clk); #2;
    chk(pwm_oe == 1'b0, "R10 oe off", pwm_oe, 0);
    meas_win(1'b0, 60, as);
    chk(as == 0, "R10 pin low", as, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule